// File: doc/BRIEF.md
# Fan Tachometer Sampling Scheduler

This block decides when the speed of a fan can be measured while the fan is powered by a pulsed drive signal. A tachometer pin only produces usable edges while the fan is powered. The block therefore opens a measurement only during the on-phase of the raw drive, and only after a settling interval (the guard time) has passed. It can optionally hold the drive on past the end of the on-phase, up to a bounded stretch time, so that a measurement already in flight can finish.

A finished measurement is the number of 90 kHz ticks between two rising tachometer edges. Measurements are committed to a 16-bit reading at a programmed update rate. In opportunistic mode, an unstretched measurement is committed the moment it completes, and that commit restarts the update timer. When an update period ends with no valid measurement, the reading is loaded with FFFFh to flag a stalled fan.

The block also applies the duty-cycle target to the duty output. A zero target either cuts the duty at once or walks it down one count per ramp tick, depending on an option bit. A six-bit option register configures the block and can be frozen by a sticky lock.

Top module: `fan_tach_sched`

## Requirements
- R1: After reset, the option register reads 0Ch, the reading is FFFFh, and the duty output, drive output and commit strobe are all 0.
- R2: Option bits are: [1:0] update rate, [2] snap-to-zero, [4:3] guard select, [5] opportunistic enable. Bits [7:6] always read 0 and ignore written data.
- R3: After a lock pulse, option writes have no effect until the next reset.
- R4: The update-rate codes give these commit periods: 00 gives TPS ticks, 01 gives TPS/2 ticks, and 10 or 11 gives 3*TPS/10 ticks. With opportunistic mode off, exactly one commit happens per period, carrying the latest valid measurement.
- R5: A period that ends with no valid measurement commits FFFFh.
- R6: Tachometer edges are ignored for a guard interval after the raw drive rises. Guard codes 00, 01, 10 and 11 give 63, 32, 16 and 8 ticks.
- R7: A measurement is the tick count between two successive rising tachometer edges seen after the guard time while the measurement is alive.
- R8: With stretching disabled, the drive output equals the raw drive, and a measurement is abandoned when the raw drive falls.
- R9: With stretching enabled, the drive output stays high after the raw drive falls until the measurement completes or stretch_max ticks have elapsed, whichever comes first.
- R10: In opportunistic mode, an unstretched measurement commits at once and restarts the update timer. A stretched one waits for the end of the period.
- R11: With snap-to-zero set, a zero target drives the duty output to 0 on the next cycle.
- R12: With snap-to-zero clear and a zero target, the duty output drops by one per ramp tick and stops at 0. Any nonzero target is applied on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 90 kHz time-base strobe, one clock wide |
| drive_raw | input | 1 | Raw pulse-width drive from the duty generator |
| tach_in | input | 1 | Synchronized tachometer input |
| stretch_en | input | 1 | Allows the on-phase to be stretched |
| stretch_max | input | SW | Stretch limit in ticks |
| reg_wr | input | 1 | Option register write strobe |
| reg_wdata | input | 8 | Option register write data |
| lock_set | input | 1 | Sets the sticky register lock |
| reg_rdata | output | 8 | Option register read value |
| duty_target | input | DW | Duty-cycle target from the control loop |
| ramp_tick | input | 1 | Ramp-rate step strobe |
| duty_out | output | DW | Applied duty cycle |
| drive_out | output | 1 | Drive to the fan, including stretch |
| tach_reading | output | CW | Committed tachometer period in ticks |
| reading_stb | output | 1 | One-cycle pulse on each commit |

## Verification
Several properties are checked on every cycle. Locked option bits never change. The measurement never goes from the guard state straight into counting. Without stretching, the drive output always equals the raw drive. An opportunistic commit always clears the update timer. The duty output never rises while the target is zero, and it follows any nonzero target. Other behaviours depend on stimulus over time and only the bench scenarios can show them: the exact period length for each update code, FFFFh on a stalled fan, the guard interval for each code, measured tick values, stretch cut-off at the limit, and the point at which a stretched measurement is committed.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_GUARD,
    MS_ARM,
    MS_MEAS
  } meas_st_e;

  // option fields, MSB first: [5] opp, [4:3] guard, [2] snap, [1:0] update
  typedef struct packed {
    logic       opp;
    logic [1:0] guard;
    logic       snap;
    logic [1:0] upd;
  } opt_t;

  localparam logic [5:0] OPT_RST = 6'h0C;

  function automatic logic [6:0] guard_ticks(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'd63;
      2'b01:   return 7'd32;
      2'b10:   return 7'd16;
      default: return 7'd8;
    endcase
  endfunction

endpackage

// File: rtl/fts_optreg.sv
module fts_optreg
  import fts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       lock_set,
  output opt_t       opt,
  output logic [7:0] rdata
);

  logic [5:0] opt_q;
  logic       lock_q;
  logic       unused_rsvd;

  assign unused_rsvd = ^wdata[7:6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q  <= OPT_RST;
      lock_q <= 1'b0;
    end else begin
      if (lock_set) lock_q <= 1'b1;
      if (wr_en && !lock_q && !lock_set) opt_q <= wdata[5:0];
    end
  end

  assign opt   = opt_t'(opt_q);
  assign rdata = {2'b00, opt_q};

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(opt_q));

endmodule

// File: rtl/fts_tach_meas.sv
module fts_tach_meas
  import fts_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          drive_raw,
  input  logic          tach_in,
  input  logic          stretch_en,
  input  logic [SW-1:0] stretch_max,
  input  logic [1:0]    guard_sel,
  output logic          drive_out,
  output logic          done,
  output logic [CW-1:0] done_val,
  output logic          done_str
);

  localparam logic [CW-1:0] SAT = {{(CW-1){1'b1}}, 1'b0};

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v, input logic inc);
    return (inc && (v < SAT)) ? v + CW'(1) : v;
  endfunction

  meas_st_e      st;
  logic          drv_q, tach_q;
  logic [6:0]    gcnt;
  logic [CW-1:0] cnt;
  logic [SW-1:0] scnt;

  logic       tach_edge, drive_rise, busy, can_stretch, stretch_act, abort;
  logic [6:0] glen;

  assign tach_edge   = tach_in && !tach_q;
  assign drive_rise  = drive_raw && !drv_q;
  assign busy        = (st != MS_IDLE);
  assign can_stretch = stretch_en && (scnt < stretch_max);
  assign stretch_act = busy && !drive_raw && can_stretch;
  assign abort       = busy && !drive_raw && !can_stretch;
  assign glen        = guard_ticks(guard_sel);

  assign done      = (st == MS_MEAS) && tach_edge && !abort;
  assign done_val  = sat_inc(cnt, tick);
  assign done_str  = !drive_raw;
  assign drive_out = drive_raw || stretch_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= MS_IDLE;
      drv_q  <= 1'b0;
      tach_q <= 1'b0;
      gcnt   <= '0;
      cnt    <= '0;
      scnt   <= '0;
    end else begin
      drv_q  <= drive_raw;
      tach_q <= tach_in;
      if (stretch_act && tick) scnt <= scnt + SW'(1);
      case (st)
        MS_IDLE: begin
          if (drive_rise) begin
            st   <= MS_GUARD;
            gcnt <= '0;
            scnt <= '0;
          end
        end
        MS_GUARD: begin
          if (abort) st <= MS_IDLE;
          else if (tick) begin
            if (gcnt + 7'd1 >= glen) st <= MS_ARM;
            else gcnt <= gcnt + 7'd1;
          end
        end
        MS_ARM: begin
          if (abort) st <= MS_IDLE;
          else if (tach_edge) begin
            st  <= MS_MEAS;
            cnt <= '0;
          end
        end
        MS_MEAS: begin
          if (abort) st <= MS_IDLE;
          else if (tach_edge) begin
            cnt <= '0;
            st  <= drive_raw ? MS_MEAS : MS_IDLE;
          end else begin
            cnt <= sat_inc(cnt, tick);
          end
        end
        default: st <= MS_IDLE;
      endcase
    end
  end

  // R6
  guard_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MS_GUARD) |=> (st != MS_MEAS));

  // R8
  no_stretch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stretch_en |-> (drive_out == drive_raw));

  // R9
  stretch_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_out && !drive_raw) |-> (stretch_en && busy && scnt <= stretch_max));

endmodule

// File: rtl/fts_commit.sv
module fts_commit #(
  parameter int TPS = 90000,
  parameter int CW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          opp_en,
  input  logic [1:0]    upd_sel,
  input  logic          done,
  input  logic [CW-1:0] done_val,
  input  logic          done_str,
  output logic [CW-1:0] reading,
  output logic          reading_stb
);

  localparam int PW = $clog2(TPS + 1);
  localparam logic [PW-1:0] P_FULL = PW'(TPS);
  localparam logic [PW-1:0] P_HALF = PW'(TPS / 2);
  localparam logic [PW-1:0] P_FAST = PW'((TPS * 3) / 10);
  localparam logic [CW-1:0] STALL  = {CW{1'b1}};

  function automatic logic [PW-1:0] per_sel(input logic [1:0] u);
    case (u)
      2'b00:   return P_FULL;
      2'b01:   return P_HALF;
      default: return P_FAST;
    endcase
  endfunction

  logic [PW-1:0] tcnt, per_len;
  logic [CW-1:0] held;
  logic          held_v, opp_hit, per_hit;

  assign per_len = per_sel(upd_sel);
  assign opp_hit = opp_en && done && !done_str;
  assign per_hit = tick && ((tcnt + PW'(1)) >= per_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt        <= '0;
      held        <= '0;
      held_v      <= 1'b0;
      reading     <= STALL;
      reading_stb <= 1'b0;
    end else begin
      reading_stb <= 1'b0;
      if (opp_hit) begin
        reading     <= done_val;
        reading_stb <= 1'b1;
        tcnt        <= '0;
        held_v      <= 1'b0;
      end else if (per_hit) begin
        reading     <= done ? done_val : (held_v ? held : STALL);
        reading_stb <= 1'b1;
        tcnt        <= '0;
        held_v      <= 1'b0;
      end else begin
        if (done) begin
          held   <= done_val;
          held_v <= 1'b1;
        end
        if (tick) tcnt <= tcnt + PW'(1);
      end
    end
  end

  // R10
  opp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opp_hit |=> (reading_stb && tcnt == '0));

  // R5
  stall_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && !opp_hit && !done && !held_v) |=> (reading == STALL));

  // R4
  period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= P_FULL);

endmodule

// File: rtl/fts_duty_ramp.sv
module fts_duty_ramp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snap_en,
  input  logic [DW-1:0] target,
  input  logic          ramp_tick,
  output logic [DW-1:0] duty
);

  logic tgt_zero, ramp_step;

  assign tgt_zero  = (target == '0);
  assign ramp_step = tgt_zero && !snap_en && ramp_tick && (duty != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             duty <= '0;
    else if (!tgt_zero)     duty <= target;
    else if (snap_en)       duty <= '0;
    else if (ramp_step)     duty <= duty - DW'(1);
  end

  // R11
  snap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_en && tgt_zero) |=> (duty == '0));

  // R12
  ramp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_zero |=> (duty <= $past(duty)));

  // R12
  target_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_zero |=> (duty == $past(target)));

endmodule

// File: rtl/fan_tach_sched.sv
module fan_tach_sched
  import fts_pkg::*;
#(
  parameter int TPS = 90000,
  parameter int CW  = 16,
  parameter int SW  = 8,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          drive_raw,
  input  logic          tach_in,
  input  logic          stretch_en,
  input  logic [SW-1:0] stretch_max,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  input  logic          lock_set,
  output logic [7:0]    reg_rdata,
  input  logic [DW-1:0] duty_target,
  input  logic          ramp_tick,
  output logic [DW-1:0] duty_out,
  output logic          drive_out,
  output logic [CW-1:0] tach_reading,
  output logic          reading_stb
);

  opt_t          opt;
  logic          m_done, m_str;
  logic [CW-1:0] m_val;

  fts_optreg u_opt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wdata    (reg_wdata),
    .lock_set (lock_set),
    .opt      (opt),
    .rdata    (reg_rdata)
  );

  fts_tach_meas #(.CW(CW), .SW(SW)) u_meas (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .drive_raw   (drive_raw),
    .tach_in     (tach_in),
    .stretch_en  (stretch_en),
    .stretch_max (stretch_max),
    .guard_sel   (opt.guard),
    .drive_out   (drive_out),
    .done        (m_done),
    .done_val    (m_val),
    .done_str    (m_str)
  );

  fts_commit #(.TPS(TPS), .CW(CW)) u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .opp_en      (opt.opp),
    .upd_sel     (opt.upd),
    .done        (m_done),
    .done_val    (m_val),
    .done_str    (m_str),
    .reading     (tach_reading),
    .reading_stb (reading_stb)
  );

  fts_duty_ramp #(.DW(DW)) u_duty (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap_en   (opt.snap),
    .target    (duty_target),
    .ramp_tick (ramp_tick),
    .duty      (duty_out)
  );

endmodule

// File: tb/fan_tach_sched_test.sv
module fan_tach_sched_test;

  localparam int TPS = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        drive_raw = 1'b0, tach_in = 1'b0, stretch_en = 1'b0;
  logic [7:0]  stretch_max = 8'd0;
  logic        reg_wr = 1'b0, lock_set = 1'b0, ramp_tick = 1'b0;
  logic [7:0]  reg_wdata = 8'd0, reg_rdata, duty_target = 8'd0, duty_out;
  logic        drive_out, reading_stb;
  logic [15:0] tach_reading;

  fan_tach_sched #(.TPS(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drive_raw(drive_raw), .tach_in(tach_in),
    .stretch_en(stretch_en), .stretch_max(stretch_max), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .lock_set(lock_set), .reg_rdata(reg_rdata),
    .duty_target(duty_target), .ramp_tick(ramp_tick), .duty_out(duty_out),
    .drive_out(drive_out), .tach_reading(tach_reading), .reading_stb(reading_stb)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [15:0] val;
    int          gap;
    string       req;
  } item_t;

  item_t q[$];
  int    vectors = 0;
  int    errors  = 0;
  int    cyc     = 0;
  int    last_stb = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input logic [15:0] v, input int gap, input string req);
    item_t it;
    it.val = v; it.gap = gap; it.req = req;
    q.push_back(it);
  endtask

  // monitor: pops one expected item per commit strobe
  always @(negedge clk) begin
    if (rst_n && reading_stb) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 unexpected commit", int'(tach_reading), 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(tach_reading == it.val, it.req, int'(tach_reading), int'(it.val));
        if (it.gap > 0) chk((cyc - last_stb) == it.gap, {it.req, " gap"}, cyc - last_stb, it.gap);
      end
      last_stb = cyc;
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; drive_raw = 1'b0; tach_in = 1'b0; stretch_en = 1'b0;
    stretch_max = 8'd0; reg_wr = 1'b0; lock_set = 1'b0; ramp_tick = 1'b0;
    duty_target = 8'd0;
    waitc(3);
    rst_n = 1'b1;
  endtask

  task automatic wr_opt(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    waitc(1);
    reg_wr = 1'b0;
  endtask

  task automatic tach_train(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1; waitc(per / 2);
      tach_in = 1'b0; waitc(per - per / 2);
    end
  endtask

  task automatic two_edges(input int e1, input int e2);
    waitc(e1); tach_in = 1'b1; waitc(2); tach_in = 1'b0;
    waitc(e2 - e1 - 2); tach_in = 1'b1; waitc(2); tach_in = 1'b0;
  endtask

  task automatic end_scn(input string req);
    chk(q.size() == 0, {req, " pending commits"}, q.size(), 0);
    q.delete();
  endtask

  task automatic guard_case(input logic [7:0] opt, input bit late, input logic [15:0] exp);
    do_reset();
    wr_opt(opt);
    drive_raw = 1'b1;
    expect_item(exp, 0, "R6 guard");
    if (opt[4:3] == 2'b00) begin
      two_edges(50, 60); two_edges(18, 33);          // edges t+50,t+60 ignored; t+80..t+95
    end else if (opt[4:3] == 2'b10) begin
      two_edges(5, 12); two_edges(13, 25);           // t+5,t+12 ignored; t+27..t+39
    end else if (late) begin
      two_edges(15, 25);
    end
    waitc(400);
    end_scn("R6");
  endtask

  task automatic stretch_case(input bit en, input logic [7:0] smax, input bit mid,
                              input logic [15:0] exp, input string req);
    do_reset();
    wr_opt(8'h3E);                                   // opp, guard 8, snap, 300-tick period
    stretch_en = en; stretch_max = smax;
    expect_item(exp, 0, req);
    drive_raw = 1'b1; waitc(10);
    drive_raw = 1'b0; waitc(5);
    if (!en) chk(drive_out == 1'b0, "R8 drive follows raw", drive_out, 0);
    waitc(15); tach_in = 1'b1; waitc(2); tach_in = 1'b0; waitc(18);
    chk(drive_out == mid, "R9 stretch mid", drive_out, mid);
    waitc(20); tach_in = 1'b1; waitc(2); tach_in = 1'b0; waitc(8);
    chk(drive_out == 1'b0, "R9 stretch released", drive_out, 0);
    waitc(400);
    end_scn(req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1 reset state, R2 field layout, R3 lock
    do_reset();
    waitc(1);
    chk(reg_rdata == 8'h0C, "R1 option reset", reg_rdata, 8'h0C);
    chk(tach_reading == 16'hFFFF, "R1 reading reset", tach_reading, 16'hFFFF);
    chk(duty_out == 8'd0, "R1 duty reset", duty_out, 0);
    chk(drive_out == 1'b0, "R1 drive reset", drive_out, 0);
    chk(reading_stb == 1'b0, "R1 strobe reset", reading_stb, 0);
    wr_opt(8'hFF); waitc(1);
    chk(reg_rdata == 8'h3F, "R2 reserved bits", reg_rdata, 8'h3F);
    lock_set = 1'b1; waitc(1); lock_set = 1'b0;
    wr_opt(8'h00); waitc(1);
    chk(reg_rdata == 8'h3F, "R3 locked write", reg_rdata, 8'h3F);

    // R4 / R7: code 00, tach period 40
    do_reset(); wr_opt(8'h0C); drive_raw = 1'b1;
    expect_item(16'd40, 0, "R4 R7 1s"); expect_item(16'd40, 1000, "R4 1s");
    tach_train(40, 60); waitc(200); end_scn("R4");

    // R4: code 01, tach period 30
    do_reset(); wr_opt(8'h0D); drive_raw = 1'b1;
    expect_item(16'd30, 0, "R4 R7 half"); expect_item(16'd30, 500, "R4 half");
    tach_train(30, 40); waitc(100); end_scn("R4");

    // R4: code 10, tach period 20
    do_reset(); wr_opt(8'h0E); drive_raw = 1'b1;
    expect_item(16'd20, 0, "R4 R7 fast"); expect_item(16'd20, 300, "R4 fast");
    tach_train(20, 30); waitc(50); end_scn("R4");

    // R5: code 11, no tach edges
    do_reset(); wr_opt(8'h0F); drive_raw = 1'b1;
    expect_item(16'hFFFF, 0, "R5 stall"); expect_item(16'hFFFF, 300, "R5 stall fast");
    waitc(650); end_scn("R5");

    // R10: opportunistic commits, then timer restart
    do_reset(); wr_opt(8'h2E); drive_raw = 1'b1; waitc(100);
    expect_item(16'd50, 0, "R10 opp");
    for (int i = 0; i < 3; i++) expect_item(16'd50, 50, "R10 opp");
    expect_item(16'hFFFF, 300, "R10 restart");
    tach_train(50, 5); waitc(400); end_scn("R10");

    // R6 guard codes
    guard_case(8'h1E, 1'b1, 16'd10);    // 8 ticks
    guard_case(8'h0E, 1'b1, 16'hFFFF);  // 32 ticks swallow both edges
    guard_case(8'h06, 1'b0, 16'd15);    // 63 ticks
    guard_case(8'h16, 1'b0, 16'd12);    // 16 ticks

    // R8 / R9 / R10 stretching
    stretch_case(1'b0, 8'd100, 1'b0, 16'hFFFF, "R8 no stretch");
    stretch_case(1'b1, 8'd100, 1'b1, 16'd40, "R10 stretched read waits");
    stretch_case(1'b1, 8'd20, 1'b0, 16'hFFFF, "R9 stretch limit");

    // R11 / R12 duty handling
    do_reset();
    duty_target = 8'd50; waitc(1);
    chk(duty_out == 8'd50, "R12 target applied", duty_out, 50);
    duty_target = 8'd0; waitc(1);
    chk(duty_out == 8'd0, "R11 snap to zero", duty_out, 0);
    wr_opt(8'h08);
    duty_target = 8'd60; waitc(1);
    duty_target = 8'd0; waitc(2);
    chk(duty_out == 8'd60, "R12 hold without ramp tick", duty_out, 60);
    ramp_tick = 1'b1; waitc(3); ramp_tick = 1'b0; waitc(1);
    chk(duty_out == 8'd57, "R12 ramp step", duty_out, 57);
    duty_target = 8'd20; waitc(1);
    chk(duty_out == 8'd20, "R12 ramp abort", duty_out, 20);
    duty_target = 8'd0; ramp_tick = 1'b1; waitc(25); ramp_tick = 1'b0; waitc(1);
    chk(duty_out == 8'd0, "R12 ramp floor", duty_out, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule